// File: doc/BRIEF.md
# EDO DRAM Block Read Sequencer

This block fetches one cache block from an asynchronous DRAM whose output data stays valid after the column strobe rises. Each fetch uses one row activation and then four column reads. A requester presents a row and a starting column. The block opens the row with the row strobe and steps through the four columns of the aligned block. The requested word comes first, and the column index wraps inside the block. Each word is handed back with a one-cycle valid strobe, and the fourth word also carries a completion flag.

The DRAM holds the previous word on its pins while the next column address is set up. Because of this, the column strobe can toggle every other cycle, and the first word arrives five cycles after acceptance and each later word two cycles after the one before it. The block also keeps a cycle counter with an interval set from outside. Whenever the interval runs out, a refresh is marked pending. The block services it only while idle, as a row-strobe-only cycle on the next row in turn.

Top module: `edo_burst_rd_ctrl`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n and dram_oe_n are 1, busy is 0 and beat_valid is 0. Whenever busy is 0, all three strobes are 1.
- R2: A request is accepted at clock edge E0 when busy is 0 and req_valid is 1. beat_valid is high in cycles 5, 7, 9 and 11 after E0 and low in the other cycles. block_done is high only together with the fourth beat, in cycle 11.
- R3: In cycle 1 dram_addr carries the requested row, zero-extended. dram_ras_n is 0 in cycles 1 through 10 and returns to 1 in cycle 11.
- R4: dram_cas_n is 0 only in cycles 3, 5, 7 and 9. Beat k's column is on dram_addr in cycles 2+2k and 3+2k, so it is already present in the cycle before its strobe. dram_oe_n is 0 in cycles 3 through 10.
- R5: Beat k (k = 0..3) uses a column whose upper bits equal req_col[COL_W-1:2] and whose two low bits are (req_col[1:0] + k) mod 4.
- R6: The data of beat k equals the DRAM word at the requested row and at beat k's column.
- R7: busy is 1 in cycles 1 through 10 of a read and is also 1 during a refresh. A req_valid presented while busy is 1 is dropped: it does not change the current read and does not start another.
- R8: With refresh_interval = N > 0, a refresh becomes pending every N cycles, and an idle block with no request starts it on the next cycle. N = 0 disables refresh. A request arriving at the same edge as a pending refresh wins.
- R9: A refresh holds dram_ras_n at 0 for T_RFC cycles while dram_cas_n and dram_oe_n stay 1. dram_addr carries a row number that starts at 0 and increases by one per refresh, wrapping at 2^ROW_W.
- R10: A refresh never starts inside a read. A refresh that becomes pending during a read waits until the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block read request |
| req_row | input | ROW_W | Row of the requested block |
| req_col | input | COL_W | Column of the first word wanted |
| refresh_interval | input | REFI_W | Cycles between refreshes, 0 disables refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | DRAM output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq | input | DATA_W | DRAM read data |
| busy | output | 1 | Read or refresh in progress |
| beat_valid | output | 1 | beat_data holds a word this cycle |
| beat_data | output | DATA_W | Returned word |
| block_done | output | 1 | Marks the last beat of a block |

## Verification
The bench builds the block with ROW_W = 4, COL_W = 6 and REFI_W = 8. With only sixteen rows, the refresh pointer wraps several times within a few thousand cycles, so R9's wrap can be checked. The 6-bit column reaches starting words near the top of the column space, where both the in-block wrap and the preserved upper bits matter. A refresh interval of 40 makes the period measurable while the block is idle. An interval of 13 is shorter than two back-to-back reads, so refreshes keep falling due during bursts and must be deferred.

// File: rtl/edo_rd_pkg.sv
package edo_rd_pkg;

    // Burst shape: four words, first after five cycles, then one every two
    localparam int BEATS   = 4;
    localparam int BEAT_W  = 2;
    localparam int T_FIRST = 5;
    localparam int T_NEXT  = 2;

    // Phase numbering inside a read (phase 1 is the cycle after acceptance)
    localparam int PH_ROW  = 1;
    localparam int PH_COL0 = PH_ROW + 1;
    localparam int PH_CAP0 = T_FIRST - 1;
    localparam int PH_CAS0 = PH_CAP0 - 1;
    localparam int PH_LAST = PH_CAP0 + T_NEXT * (BEATS - 1);
    localparam int PH_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_REFR = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic oe_n;
    } dram_ctl_t;

    localparam dram_ctl_t CTL_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, oe_n: 1'b1};

    // Phase at whose closing edge a data word is captured
    function automatic logic is_cap_phase(input logic [PH_W-1:0] ph);
        int p;
        p = int'(ph);
        return (p >= PH_CAP0) && (p <= PH_LAST) && (((p - PH_CAP0) % T_NEXT) == 0);
    endfunction

    // Column strobe is low one phase before each capture
    function automatic logic is_cas_phase(input logic [PH_W-1:0] ph);
        return is_cap_phase(ph + PH_W'(1));
    endfunction

    // Which beat's column is driven in a given phase
    function automatic logic [BEAT_W-1:0] beat_of_phase(input logic [PH_W-1:0] ph);
        int p;
        int k;
        p = int'(ph);
        k = (p < PH_COL0) ? 0 : (p - PH_COL0) / T_NEXT;
        if (k > BEATS - 1) k = BEATS - 1;
        return BEAT_W'(k);
    endfunction

    // Low column bits advance by beat index and wrap inside the block
    function automatic logic [BEAT_W-1:0] wrap_low(input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] k);
        return start + k;
    endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer
    import edo_rd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int REFI_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REFI_W-1:0] interval,
    input  logic              ref_done,
    output logic              ref_pending,
    output logic [ROW_W-1:0]  ref_row
);

    logic [REFI_W-1:0] cnt_q;
    logic              expire;

    assign expire = (interval != '0) && (cnt_q >= interval - REFI_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            if (interval == '0 || expire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + REFI_W'(1);
            end

            if (expire) begin
                ref_pending <= 1'b1;
            end else if (ref_done) begin
                ref_pending <= 1'b0;
            end

            if (ref_done) begin
                ref_row <= ref_row + ROW_W'(1);
            end
        end
    end

endmodule

// File: rtl/edo_burst_seq.sv
module edo_burst_seq
    import edo_rd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int ADDR_W = 12,
    parameter int T_RFC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              ref_pending,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              busy,
    output dram_ctl_t         ctl,
    output logic [ADDR_W-1:0] addr,
    output logic              cap_en,
    output logic              cap_last,
    output logic              ref_done
);

    seq_state_e        state_q;
    logic [PH_W-1:0]   ph_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  beat_col;
    logic [BEAT_W-1:0] beat_k;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q <= ST_READ;
                        ph_q    <= PH_W'(PH_ROW);
                        row_q   <= req_row;
                        col_q   <= req_col;
                    end else if (ref_pending) begin
                        state_q <= ST_REFR;
                        ph_q    <= PH_W'(1);
                    end
                end
                ST_READ: begin
                    if (ph_q == PH_W'(PH_LAST)) begin
                        state_q <= ST_IDLE;
                        ph_q    <= '0;
                    end else begin
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                ST_REFR: begin
                    if (ph_q == PH_W'(T_RFC)) begin
                        state_q <= ST_IDLE;
                        ph_q    <= '0;
                    end else begin
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    ph_q    <= '0;
                end
            endcase
        end
    end

    assign beat_k   = beat_of_phase(ph_q);
    assign beat_col = {col_q[COL_W-1:BEAT_W], wrap_low(col_q[BEAT_W-1:0], beat_k)};

    always_comb begin
        ctl  = CTL_QUIET;
        addr = '0;
        unique case (state_q)
            ST_READ: begin
                ctl.ras_n = 1'b0;
                ctl.cas_n = !is_cas_phase(ph_q);
                ctl.oe_n  = !(ph_q >= PH_W'(PH_CAS0));
                addr      = (ph_q == PH_W'(PH_ROW)) ? ADDR_W'(row_q) : ADDR_W'(beat_col);
            end
            ST_REFR: begin
                ctl.ras_n = 1'b0;
                addr      = ADDR_W'(ref_row);
            end
            default: begin
                ctl  = CTL_QUIET;
                addr = '0;
            end
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign cap_en   = (state_q == ST_READ) && is_cap_phase(ph_q);
    assign cap_last = cap_en && (ph_q == PH_W'(PH_LAST));
    assign ref_done = (state_q == ST_REFR) && (ph_q == PH_W'(T_RFC));

endmodule

// File: rtl/edo_beat_capture.sv
module edo_beat_capture #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic              cap_last,
    input  logic [DATA_W-1:0] dq,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output logic              block_done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_valid <= 1'b0;
            beat_data  <= '0;
            block_done <= 1'b0;
        end else begin
            beat_valid <= cap_en;
            block_done <= cap_last;
            if (cap_en) begin
                beat_data <= dq;
            end
        end
    end

endmodule

// File: rtl/edo_burst_rd_ctrl.sv
module edo_burst_rd_ctrl
    import edo_rd_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10,
    parameter int DATA_W = 64,
    parameter int REFI_W = 16,
    parameter int T_RFC  = 3,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [REFI_W-1:0] refresh_interval,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_oe_n,
    output logic [ADDR_W-1:0] dram_addr,
    input  logic [DATA_W-1:0] dram_dq,
    output logic              busy,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output logic              block_done
);

    logic             ref_pending;
    logic             ref_done;
    logic [ROW_W-1:0] ref_row;
    logic             cap_en;
    logic             cap_last;
    dram_ctl_t        ctl;

    edo_refresh_timer #(
        .ROW_W  (ROW_W),
        .REFI_W (REFI_W)
    ) refresh_i (
        .clk         (clk),
        .rst         (rst),
        .interval    (refresh_interval),
        .ref_done    (ref_done),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    edo_burst_seq #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .ADDR_W (ADDR_W),
        .T_RFC  (T_RFC)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_row     (req_row),
        .req_col     (req_col),
        .ref_pending (ref_pending),
        .ref_row     (ref_row),
        .busy        (busy),
        .ctl         (ctl),
        .addr        (dram_addr),
        .cap_en      (cap_en),
        .cap_last    (cap_last),
        .ref_done    (ref_done)
    );

    edo_beat_capture #(
        .DATA_W (DATA_W)
    ) capture_i (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .cap_last   (cap_last),
        .dq         (dram_dq),
        .beat_valid (beat_valid),
        .beat_data  (beat_data),
        .block_done (block_done)
    );

    assign dram_ras_n = ctl.ras_n;
    assign dram_cas_n = ctl.cas_n;
    assign dram_oe_n  = ctl.oe_n;

endmodule

// File: rtl/edo_burst_rd_ctrl_chk.sv
module edo_burst_rd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_oe_n,
    input logic beat_valid,
    input logic block_done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dram_ras_n && dram_cas_n && dram_oe_n));

    assert_done_on_beat_R2: assert property (@(posedge clk) disable iff (rst)
        block_done |-> beat_valid);

    assert_beat_gap_R2: assert property (@(posedge clk) disable iff (rst)
        beat_valid |=> !beat_valid);

    assert_beat_cadence_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !block_done) |-> ##2 beat_valid);

    assert_cas_inside_row_R4: assert property (@(posedge clk) disable iff (rst)
        !dram_cas_n |-> !dram_ras_n);

    assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    assert_refresh_no_col_R9: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && dram_oe_n) |-> dram_cas_n);

    assert_row_held_in_burst_R10: assert property (@(posedge clk) disable iff (rst)
        (!dram_ras_n && !dram_oe_n) |=> (!dram_ras_n || beat_valid));

endmodule

bind edo_burst_rd_ctrl edo_burst_rd_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .busy       (busy),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_oe_n  (dram_oe_n),
    .beat_valid (beat_valid),
    .block_done (block_done)
);

// File: tb/edo_burst_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module edo_burst_rd_ctrl_tb_top;

    localparam int ROW_W  = 4;
    localparam int COL_W  = 6;
    localparam int DATA_W = 64;
    localparam int REFI_W = 8;
    localparam int T_RFC  = 3;
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [REFI_W-1:0] refresh_interval = '0;
    logic              dram_ras_n, dram_cas_n, dram_oe_n;
    logic [ADDR_W-1:0] dram_addr;
    logic [DATA_W-1:0] dram_dq;
    logic              busy, beat_valid, block_done;
    logic [DATA_W-1:0] beat_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    edo_burst_rd_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
        .REFI_W (REFI_W), .T_RFC (T_RFC)
    ) dut_i (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_row (req_row),
        .req_col (req_col), .refresh_interval (refresh_interval),
        .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n), .dram_oe_n (dram_oe_n),
        .dram_addr (dram_addr), .dram_dq (dram_dq), .busy (busy),
        .beat_valid (beat_valid), .beat_data (beat_data), .block_done (block_done)
    );

    // Reference memory contents, computed from the address
    function automatic logic [DATA_W-1:0] mem_word(input logic [ROW_W-1:0] r,
                                                   input logic [COL_W-1:0] c);
        logic [63:0] v;
        v = (64'(r) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
        v = v ^ ((64'(c) + 64'd3) * 64'h0123_4567_89AB_CDEF);
        return v ^ {8'(r), 8'(c), 48'h5A5A_0F0F_3C3C};
    endfunction

    function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] c, input int k);
        logic [1:0] lo;
        lo = c[1:0] + 2'(k);
        return {c[COL_W-1:2], lo};
    endfunction

    // DRAM model: row latched on row strobe fall, data held until next column strobe
    logic             ras_q = 1'b1, cas_q = 1'b1;
    logic [ROW_W-1:0] row_l = '0;
    logic [DATA_W-1:0] dq_q = '0;
    always @(posedge clk) begin
        ras_q <= dram_ras_n;
        cas_q <= dram_cas_n;
        if (ras_q && !dram_ras_n) row_l <= dram_addr[ROW_W-1:0];
        if (cas_q && !dram_cas_n) dq_q <= mem_word(row_l, dram_addr[COL_W-1:0]);
    end
    assign dram_dq = dram_oe_n ? '0 : dq_q;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Refresh monitor
    bit               in_read = 1'b0;
    bit               in_ref  = 1'b0;
    logic             prev_ras = 1'b1;
    int               ref_len = 0;
    int               ref_count = 0;
    int               last_ref_cyc = 0;
    logic [ROW_W-1:0] exp_ref_row = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (in_ref) begin
                if (!dram_ras_n) begin
                    ref_len++;
                    chk("R9 refresh strobes", {62'd0, dram_cas_n, dram_oe_n}, 64'd3);
                end else begin
                    chk("R9 refresh length", 64'(ref_len), 64'(T_RFC));
                    in_ref = 1'b0;
                end
            end else if (prev_ras && !dram_ras_n && !in_read) begin
                chk("R9 refresh row", 64'(dram_addr), 64'(exp_ref_row));
                chk("R9 refresh strobes", {62'd0, dram_cas_n, dram_oe_n}, 64'd3);
                exp_ref_row  = exp_ref_row + 1'b1;
                ref_count++;
                last_ref_cyc = cyc;
                ref_len      = 1;
                in_ref       = 1'b1;
            end
        end
        prev_ras = dram_ras_n;
    end

    // One block read; caller is at a negedge. junk drives a stray request mid-burst.
    task automatic do_read(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                           input bit junk);
        while (busy) @(negedge clk);
        in_read   = 1'b1;
        req_valid = 1'b1;
        req_row   = r;
        req_col   = c;
        for (int t = 1; t <= 11; t++) begin
            @(negedge clk);
            if (t == 1) req_valid = 1'b0;
            if (junk && t == 3) begin
                req_valid = 1'b1;
                req_row   = ~r;
                req_col   = ~c;
            end
            if (junk && t == 4) req_valid = 1'b0;
            chk("R7 busy", 64'(busy), 64'(t <= 10));
            chk("R3 ras", 64'(dram_ras_n), 64'(!(t <= 10)));
            if (t == 1) chk("R3 R8 row address", 64'(dram_addr), 64'(r));
            chk("R4 cas", 64'(dram_cas_n), 64'(!(t == 3 || t == 5 || t == 7 || t == 9)));
            chk("R4 oe", 64'(dram_oe_n), 64'(!(t >= 3 && t <= 10)));
            if (t >= 2 && t <= 9)
                chk("R4 R5 column address", 64'(dram_addr), 64'(beat_col(c, (t - 2) / 2)));
            chk("R2 beat valid", 64'(beat_valid), 64'(t == 5 || t == 7 || t == 9 || t == 11));
            chk("R2 block done", 64'(block_done), 64'(t == 11));
            if (t == 5 || t == 7 || t == 9 || t == 11)
                chk("R6 beat data", beat_data, mem_word(r, beat_col(c, (t - 5) / 2)));
        end
        in_read = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_init;
        int n0;
        int c1;
        int c2;
        int base;
        seed_init = $urandom(32'd20240613);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset strobes", {61'd0, dram_ras_n, dram_cas_n, dram_oe_n}, 64'd7);
        chk("R1 reset busy/valid", {62'd0, busy, beat_valid}, 64'd0);

        // Directed reads with refresh disabled
        do_read(4'd3, 6'd0, 1'b0);
        do_read(4'd5, 6'd3, 1'b0);                // low bits wrap 3,0,1,2
        do_read(4'd15, 6'd63, 1'b0);              // top corner, upper bits kept
        do_read(4'd9, 6'd22, 1'b0);
        do_read(4'd2, 6'd41, 1'b1);               // stray request mid-burst
        for (int t = 12; t <= 13; t++) begin
            @(negedge clk);
            chk("R7 stray request dropped busy", 64'(busy), 64'd0);
            chk("R7 stray request dropped ras", 64'(dram_ras_n), 64'd1);
        end

        // Refresh disabled: no row strobe activity while idle
        n0 = ref_count;
        repeat (300) @(negedge clk);
        chk("R8 interval zero disables refresh", 64'(ref_count), 64'(n0));

        // Refresh period while idle
        refresh_interval = 8'd40;
        n0 = ref_count;
        while (ref_count == n0) @(negedge clk);
        c1 = last_ref_cyc;
        while (ref_count == n0 + 1) @(negedge clk);
        c2 = last_ref_cyc;
        chk("R8 refresh period", 64'(c2 - c1), 64'd40);
        while (ref_count < n0 + 20) @(negedge clk);   // row pointer wraps (R9)

        // Random reads with a short refresh interval, refreshes land between bursts
        refresh_interval = 8'd13;
        base = ref_count;
        for (int i = 0; i < 150; i++) begin
            int gap;
            gap = int'($urandom_range(0, 3));
            repeat (gap) @(negedge clk);
            do_read(ROW_W'($urandom), COL_W'($urandom), 1'b0);
        end
        repeat (20) @(negedge clk);
        chk("R10 refreshes serviced between bursts", 64'(ref_count > base + 20), 64'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule